// File: doc/BRIEF.md
# Asynchronous DRAM Module Controller

This block sits between a 32-bit processor bus and a single bank of 72-pin fast-page or extended-data-out DRAM modules. A CPU cycle comes in as a request with a word address, a write flag, four byte enables and write data. The controller splits the word address into a row part and a column part and drives them on a shared address bus. The row goes out with the row strobe, then the column goes out with the per-lane column strobes. The strobes are held through a data-settle phase, and then the cycle is acknowledged for one clock.

Refresh uses the column-before-row scheme. A free-running interval counter raises a refresh request that stays latched until the sequencer serves it. When an idle sequencer sees a refresh request and a CPU request together, refresh goes first. Straight after reset the sequencer runs a fixed burst of refresh cycles back to back, before it accepts any CPU cycle. It has no power-on delay of its own, because the external reset is assumed to last long enough.

A small geometry register is reached with a register-select input. It holds the column and row address widths, each from 8 to 12 bits. Modules of the same capacity but different organisation therefore both appear as one gap-free block of word addresses.

Top module: `dram_ctl`

## Requirements
- R1: While reset is low and right after it, dram_ras_n and dram_we_n are 1, dram_cas_n is 4'hF, cpu_ack is 0, and the geometry register reads back 8'hCC (row width 12, column width 12).
- R2: After reset, INIT_REFRESH (8) refresh cycles finish before the first CPU cycle (memory or register) is acknowledged.
- R3: A refresh drives all four dram_cas_n low exactly one clock before dram_ras_n falls. Both then stay low for T_REF clocks and rise in the same clock.
- R4: Refresh requests arise every REF_INTERVAL clocks. A request that comes up during a CPU cycle is kept and served afterwards, so the gap between refreshes stays near REF_INTERVAL under steady CPU traffic.
- R5: When an idle sequencer sees a refresh request and a CPU request in the same clock, it starts the refresh first.
- R6: A memory cycle holds dram_ras_n low with the row address for T_RCD clocks before any column strobe falls. The strobes then stay asserted for T_CAS more clocks, and cpu_ack pulses for exactly one clock, T_CAS+1 clocks after the column strobe fell.
- R7: With column width C and row width W, the column address is cpu_addr[C-1:0] and the row address is bits [C+W-1:C] of cpu_addr, each zero-extended on dram_addr.
- R8: On a write, dram_cas_n[i] is low exactly when cpu_be[i] is 1 (lane i is data bits 8i+7:8i), dram_we_n is 0 and dram_dq_out carries cpu_wdata. On a read, all four strobes go low, dram_we_n is 1, and cpu_rdata returns dram_dq_in sampled at the end of the settle phase.
- R9: Before every falling edge of dram_ras_n, dram_ras_n has been high for at least T_PRE clocks.
- R10: A request with cpu_cfg_sel set is acknowledged in one clock. A write sets the column width from cpu_wdata[3:0] and the row width from cpu_wdata[7:4], each clamped to the range 8..12. A read returns {row width, column width} on cpu_rdata[7:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | CPU cycle request, held until cpu_ack |
| cpu_cfg_sel | input | 1 | Selects the geometry register instead of memory |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_be | input | 4 | Byte-lane enables for writes |
| cpu_addr | input | CPU_AW | Word address |
| cpu_wdata | input | 32 | Write data |
| cpu_ack | output | 1 | One-clock cycle acknowledge |
| cpu_rdata | output | 32 | Read data, valid with cpu_ack |
| dram_addr | output | DRAM_AW | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 4 | Column strobes per byte lane, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_dq_out | output | 32 | Data toward the modules |
| dram_dq_oe | output | 1 | Output enable for dram_dq_out |
| dram_dq_in | input | 32 | Data from the modules |

## Verification
The checker assumes that the CPU keeps cpu_req and its address, data and select inputs steady from the request until the acknowledge. It also assumes that cpu_req is dropped in the acknowledge clock. The bench drives every cycle through one task that does exactly this, and it only uses non-zero byte enables for writes. The DRAM is a behavioural model in the bench that reacts to the strobe edges, so the strobe-order, precharge and refresh-priority properties only rely on the controller's own outputs. Addresses are drawn at random, but always below the capacity that the current geometry gives.

// File: rtl/dram_pkg.sv
// Shared types and helpers for the DRAM module controller.
// Assumes geometry widths are expressed in bits and never exceed 12.
package dram_pkg;

    localparam logic [3:0] GEO_MIN = 4'd8;
    localparam logic [3:0] GEO_MAX = 4'd12;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ROW,
        ST_COL,
        ST_SETTLE,
        ST_ACK,
        ST_PRE,
        ST_CBR_CAS,
        ST_CBR_RAS,
        ST_CFG
    } seq_state_t;

    typedef struct packed {
        logic [3:0] row_w;
        logic [3:0] col_w;
    } geom_t;

    // Limit a requested address width to the supported span.
    function automatic logic [3:0] clamp_width(input logic [3:0] v);
        if (v < GEO_MIN) return GEO_MIN;
        if (v > GEO_MAX) return GEO_MAX;
        return v;
    endfunction

endpackage

// File: rtl/dram_refresh_timer.sv
// Free-running refresh interval counter with a sticky request flag.
// Assumes the sequencer pulses 'take' for one clock when it starts a refresh.
module dram_refresh_timer #(
    parameter int INTERVAL = 3120
) (
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    output logic due
);
    localparam int CNT_W = $clog2(INTERVAL);

    logic [CNT_W-1:0] cnt;
    logic             expire;

    assign expire = (cnt == '0);

    // Count down and reload on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= CNT_W'(INTERVAL - 1);
        else if (expire)  cnt <= CNT_W'(INTERVAL - 1);
        else              cnt <= cnt - 1'b1;
    end

    // Hold the request until the sequencer takes it; a new expiry wins.
    always_ff @(posedge clk) begin
        if (!rst_n) due <= 1'b0;
        else        due <= expire | (due & ~take);
    end
endmodule

// File: rtl/dram_geom_reg.sv
// Geometry register holding the row and column address widths.
// Assumes writes arrive as a single-clock strobe; values are clamped on entry.
module dram_geom_reg
    import dram_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [7:0] wdata,
    output geom_t      geom
);
    // Store clamped widths; default to the widest organisation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            geom.row_w <= GEO_MAX;
            geom.col_w <= GEO_MAX;
        end else if (wr) begin
            geom.row_w <= clamp_width(wdata[7:4]);
            geom.col_w <= clamp_width(wdata[3:0]);
        end
    end
endmodule

// File: rtl/dram_addr_mux.sv
// Splits a flat word address into row and column parts by the geometry.
// Assumes CPU_AW >= DRAM_AW and widths held in geom are at most DRAM_AW.
module dram_addr_mux
    import dram_pkg::*;
#(
    parameter int CPU_AW  = 24,
    parameter int DRAM_AW = 12
) (
    input  logic [CPU_AW-1:0]  addr,
    input  geom_t              geom,
    output logic [DRAM_AW-1:0] row,
    output logic [DRAM_AW-1:0] col
);
    logic [CPU_AW-1:0]  shifted;
    logic [DRAM_AW-1:0] col_mask;
    logic [DRAM_AW-1:0] row_mask;

    // Mask off bits beyond each programmed width.
    always_comb begin
        shifted  = addr >> geom.col_w;
        col_mask = ~({DRAM_AW{1'b1}} << geom.col_w);
        row_mask = ~({DRAM_AW{1'b1}} << geom.row_w);
        col      = addr[DRAM_AW-1:0] & col_mask;
        row      = shifted[DRAM_AW-1:0] & row_mask;
    end
endmodule

// File: rtl/dram_ctl.sv
// DRAM module controller: CPU request/acknowledge port to RAS/CAS/WE pins.
// Assumes the CPU holds its request inputs until cpu_ack and drops cpu_req in
// the acknowledge clock; the external reset already covers power-on settling.
module dram_ctl
    import dram_pkg::*;
#(
    parameter int CPU_AW       = 24,
    parameter int DRAM_AW      = 12,
    parameter int DATA_W       = 32,
    parameter int REF_INTERVAL = 3120,
    parameter int T_RCD        = 3,
    parameter int T_CAS        = 3,
    parameter int T_PRE        = 3,
    parameter int T_REF        = 4,
    parameter int INIT_REFRESH = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cpu_req,
    input  logic                  cpu_cfg_sel,
    input  logic                  cpu_we,
    input  logic [DATA_W/8-1:0]   cpu_be,
    input  logic [CPU_AW-1:0]     cpu_addr,
    input  logic [DATA_W-1:0]     cpu_wdata,
    output logic                  cpu_ack,
    output logic [DATA_W-1:0]     cpu_rdata,
    output logic [DRAM_AW-1:0]    dram_addr,
    output logic                  dram_ras_n,
    output logic [DATA_W/8-1:0]   dram_cas_n,
    output logic                  dram_we_n,
    output logic [DATA_W-1:0]     dram_dq_out,
    output logic                  dram_dq_oe,
    input  logic [DATA_W-1:0]     dram_dq_in
);
    localparam int LANES  = DATA_W / 8;
    localparam int WMAX_A = (T_RCD > T_CAS) ? T_RCD : T_CAS;
    localparam int WMAX_B = (T_PRE > T_REF) ? T_PRE : T_REF;
    localparam int WMAX   = (WMAX_A > WMAX_B) ? WMAX_A : WMAX_B;
    localparam int WAIT_W = $clog2(WMAX + 1);
    localparam int INIT_W = $clog2(INIT_REFRESH + 1);

    seq_state_t           st;
    logic [WAIT_W-1:0]    wait_cnt;
    logic [INIT_W-1:0]    init_left;
    logic                 ref_due;
    logic                 ref_take;
    logic                 lat_we;
    logic [LANES-1:0]     lat_be;
    logic [CPU_AW-1:0]    lat_addr;
    logic [DATA_W-1:0]    lat_wdata;
    geom_t                geom;
    logic [DRAM_AW-1:0]   row_addr;
    logic [DRAM_AW-1:0]   col_addr;
    logic                 geom_wr;
    logic                 strobe_phase;

    assign ref_take     = (st == ST_IDLE) && ((init_left != '0) || ref_due);
    assign geom_wr      = (st == ST_CFG) && cpu_we;
    assign strobe_phase = (st == ST_COL) || (st == ST_SETTLE);

    dram_refresh_timer #(.INTERVAL(REF_INTERVAL)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .take  (ref_take),
        .due   (ref_due)
    );

    dram_geom_reg u_geom (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (geom_wr),
        .wdata (cpu_wdata[7:0]),
        .geom  (geom)
    );

    dram_addr_mux #(.CPU_AW(CPU_AW), .DRAM_AW(DRAM_AW)) u_mux (
        .addr (lat_addr),
        .geom (geom),
        .row  (row_addr),
        .col  (col_addr)
    );

    // Sequencer: refresh first, then register or memory cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_PRE;
            wait_cnt  <= WAIT_W'(T_PRE - 1);
            init_left <= INIT_W'(INIT_REFRESH);
            lat_we    <= 1'b0;
            lat_be    <= '0;
            lat_addr  <= '0;
            lat_wdata <= '0;
            cpu_rdata <= '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (ref_take) begin
                        st <= ST_CBR_CAS;
                        if (init_left != '0) init_left <= init_left - 1'b1;
                    end else if (cpu_req && cpu_cfg_sel) begin
                        st        <= ST_CFG;
                        cpu_rdata <= DATA_W'(geom);
                    end else if (cpu_req) begin
                        st        <= ST_ROW;
                        wait_cnt  <= WAIT_W'(T_RCD - 1);
                        lat_we    <= cpu_we;
                        lat_be    <= cpu_be;
                        lat_addr  <= cpu_addr;
                        lat_wdata <= cpu_wdata;
                    end
                end
                ST_ROW: begin
                    if (wait_cnt == '0) st <= ST_COL;
                    else                wait_cnt <= wait_cnt - 1'b1;
                end
                ST_COL: begin
                    st       <= ST_SETTLE;
                    wait_cnt <= WAIT_W'(T_CAS - 1);
                end
                ST_SETTLE: begin
                    if (wait_cnt == '0) begin
                        st        <= ST_ACK;
                        cpu_rdata <= dram_dq_in;
                    end else begin
                        wait_cnt <= wait_cnt - 1'b1;
                    end
                end
                ST_ACK: begin
                    st       <= ST_PRE;
                    wait_cnt <= WAIT_W'(T_PRE - 1);
                end
                ST_PRE: begin
                    if (wait_cnt == '0) st <= ST_IDLE;
                    else                wait_cnt <= wait_cnt - 1'b1;
                end
                ST_CBR_CAS: begin
                    st       <= ST_CBR_RAS;
                    wait_cnt <= WAIT_W'(T_REF - 1);
                end
                ST_CBR_RAS: begin
                    if (wait_cnt == '0) begin
                        st       <= ST_PRE;
                        wait_cnt <= WAIT_W'(T_PRE - 1);
                    end else begin
                        wait_cnt <= wait_cnt - 1'b1;
                    end
                end
                ST_CFG:  st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Row strobe and shared address bus follow the sequencer phase.
    always_comb begin
        dram_ras_n = !((st == ST_ROW) || strobe_phase || (st == ST_CBR_RAS));
        if (st == ST_ROW)      dram_addr = row_addr;
        else if (strobe_phase) dram_addr = col_addr;
        else                   dram_addr = '0;
    end

    // Per-lane column strobes: lane enables on writes, all lanes otherwise.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_comb begin
            if ((st == ST_CBR_CAS) || (st == ST_CBR_RAS))
                dram_cas_n[i] = 1'b0;
            else if (strobe_phase)
                dram_cas_n[i] = lat_we ? !lat_be[i] : 1'b0;
            else
                dram_cas_n[i] = 1'b1;
        end
    end

    // Write enable, data drive and acknowledge.
    always_comb begin
        dram_we_n   = !(strobe_phase && lat_we);
        dram_dq_oe  = strobe_phase && lat_we;
        dram_dq_out = lat_wdata;
        cpu_ack     = (st == ST_ACK) || (st == ST_CFG);
    end
endmodule

// File: rtl/dram_ctl_chk.sv
// Property checker for dram_ctl, attached by bind.
// Assumes it sees the controller's pins and its sequencer state.
module dram_ctl_chk
    import dram_pkg::*;
#(
    parameter int T_PRE = 3
) (
    input logic       clk,
    input logic       rst_n,
    input logic       ras_n,
    input logic [3:0] cas_n,
    input logic       ack,
    input logic       req,
    input logic       ref_due,
    input seq_state_t st,
    input geom_t      geom
);
    logic [7:0] hi_cnt;

    // Count clocks the row strobe has been high.
    always_ff @(posedge clk) begin
        if (!rst_n)                hi_cnt <= '0;
        else if (!ras_n)           hi_cnt <= '0;
        else if (hi_cnt != 8'hFF)  hi_cnt <= hi_cnt + 1'b1;
    end

    AST_CBR_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && (cas_n == 4'h0)) |-> ($past(cas_n) == 4'h0)); // R3
    AST_ROW_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n && ($past(cas_n) == 4'hF) && (cas_n != 4'hF)) |-> $past(!ras_n)); // R6
    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack); // R6
    AST_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (hi_cnt >= 8'(T_PRE))); // R9
    AST_REFRESH_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_IDLE) && ref_due && req) |=> (st == ST_CBR_CAS)); // R5
    AST_GEOM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (geom.col_w >= GEO_MIN) && (geom.col_w <= GEO_MAX) &&
        (geom.row_w >= GEO_MIN) && (geom.row_w <= GEO_MAX)); // R10
endmodule

bind dram_ctl dram_ctl_chk #(.T_PRE(T_PRE)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ras_n   (dram_ras_n),
    .cas_n   (dram_cas_n),
    .ack     (cpu_ack),
    .req     (cpu_req),
    .ref_due (ref_due),
    .st      (st),
    .geom    (geom)
);

// File: tb/sim_dram_ctl.sv
`timescale 1ns/1ps
module sim_dram_ctl;
    localparam int RI   = 200;
    localparam int TR   = 2;
    localparam int TC   = 2;
    localparam int TP   = 3;
    localparam int TF   = 3;
    localparam int NI   = 8;
    localparam int AW   = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_cfg_sel = 1'b0, cpu_we = 1'b0;
    logic [3:0]  cpu_be = 4'h0;
    logic [AW-1:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_ack;
    logic [31:0] cpu_rdata;
    logic [11:0] dram_addr;
    logic        dram_ras_n, dram_we_n, dram_dq_oe;
    logic [3:0]  dram_cas_n;
    logic [31:0] dram_dq_out;
    logic [31:0] dram_dq_in = '0;

    always #2.5 clk = ~clk;

    dram_ctl #(.CPU_AW(AW), .REF_INTERVAL(RI), .T_RCD(TR), .T_CAS(TC),
               .T_PRE(TP), .T_REF(TF), .INIT_REFRESH(NI)) u0 (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_cfg_sel(cpu_cfg_sel),
        .cpu_we(cpu_we), .cpu_be(cpu_be), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata), .dram_addr(dram_addr),
        .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
        .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in));

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // Bench view of the current operation and geometry.
    int cur_rw = 12, cur_cw = 12;
    bit op_we, op_cfg;
    logic [3:0]  op_be;
    logic [AW-1:0] op_addr;
    logic [31:0] dram_mem [int];
    logic [31:0] exp_mem  [int];

    function automatic int clampw(input int v);
        if (v < 8) return 8;
        if (v > 12) return 12;
        return v;
    endfunction

    // Strobe monitor and DRAM model.
    bit prev_ras; logic [3:0] prev_cas;
    int hi_cnt, low_cnt, cyc, ref_cnt, last_ref, cas_cyc;
    bit in_cbr;
    logic [11:0] row_seen;
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_ras = 1; prev_cas = 4'hF; hi_cnt = 0; low_cnt = 0;
            cyc = 0; ref_cnt = 0; last_ref = 0; in_cbr = 0; cas_cyc = 0;
        end else begin
            cyc++;
            if (prev_ras && !dram_ras_n) begin
                chk(hi_cnt >= TP, "R9", "precharge clocks", hi_cnt, TP);
                if (dram_cas_n == 4'h0) begin
                    chk(prev_cas == 4'h0, "R3", "cas lead", prev_cas, 0);
                    in_cbr = 1; ref_cnt++;
                    if (ref_cnt >= NI + 2)
                        chk((cyc - last_ref >= RI - 20) && (cyc - last_ref <= RI + 20),
                            "R4", "refresh gap", cyc - last_ref, RI);
                    last_ref = cyc;
                end else begin
                    in_cbr = 0; row_seen = dram_addr;
                end
                low_cnt = 1;
            end else if (!dram_ras_n) low_cnt++;
            if (!prev_ras && dram_ras_n && in_cbr)
                chk(low_cnt == TF && dram_cas_n == 4'hF, "R3", "refresh hold", low_cnt, TF);
            if (!dram_ras_n && !prev_ras && prev_cas == 4'hF && dram_cas_n != 4'hF) begin
                int erow, ecol, key;
                chk(low_cnt == TR + 1, "R6", "row phase clocks", low_cnt - 1, TR);
                ecol = int'(op_addr) & ((1 << cur_cw) - 1);
                erow = (int'(op_addr) >> cur_cw) & ((1 << cur_rw) - 1);
                chk(row_seen == erow[11:0], "R7", "row address", row_seen, erow);
                chk(dram_addr == ecol[11:0], "R7", "column address", dram_addr, ecol);
                chk(dram_cas_n == (op_we ? ~op_be : 4'h0), "R8", "cas lanes", dram_cas_n,
                    op_we ? ~op_be : 4'h0);
                chk(dram_we_n == !op_we, "R8", "we_n", dram_we_n, !op_we);
                key = (int'(row_seen) << 12) | int'(dram_addr);
                if (op_we) begin
                    logic [31:0] v;
                    v = dram_mem.exists(key) ? dram_mem[key] : 32'h0;
                    for (int i = 0; i < 4; i++)
                        if (!dram_cas_n[i]) v[8*i +: 8] = dram_dq_out[8*i +: 8];
                    dram_mem[key] = v;
                end else begin
                    dram_dq_in = dram_mem.exists(key) ? dram_mem[key] : 32'h0;
                end
                cas_cyc = cyc;
            end
            if (cpu_ack && !op_cfg)
                chk(cyc - cas_cyc == TC + 1, "R6", "ack delay", cyc - cas_cyc, TC + 1);
            if (dram_ras_n) hi_cnt++; else hi_cnt = 0;
            prev_ras = dram_ras_n; prev_cas = dram_cas_n;
        end
    end

    task automatic cycle(input bit cfg, input bit we, input logic [3:0] be,
                         input logic [AW-1:0] a, input logic [31:0] wd,
                         output logic [31:0] rd);
        @(negedge clk);
        op_cfg = cfg; op_we = we; op_be = be; op_addr = a;
        cpu_cfg_sel = cfg; cpu_we = we; cpu_be = be; cpu_addr = a; cpu_wdata = wd;
        cpu_req = 1;
        do @(negedge clk); while (!cpu_ack);
        rd = cpu_rdata;
        cpu_req = 0;
    endtask

    task automatic set_geom(input logic [7:0] v);
        logic [31:0] rd;
        cycle(1, 1, 4'h0, '0, {24'h0, v}, rd);
        cur_cw = clampw(int'(v[3:0])); cur_rw = clampw(int'(v[7:4]));
        dram_mem.delete(); exp_mem.delete();
        cycle(1, 0, 4'h0, '0, 32'h0, rd);
        chk(rd[7:0] == {4'(cur_rw), 4'(cur_cw)}, "R10", "geometry readback", rd[7:0],
            {4'(cur_rw), 4'(cur_cw)});
    endtask

    task automatic mem_write(input logic [AW-1:0] a, input logic [3:0] be, input logic [31:0] d);
        logic [31:0] rd, v;
        cycle(0, 1, be, a, d, rd);
        v = exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : 32'h0;
        for (int i = 0; i < 4; i++) if (be[i]) v[8*i +: 8] = d[8*i +: 8];
        exp_mem[int'(a)] = v;
    endtask

    task automatic mem_read(input logic [AW-1:0] a);
        logic [31:0] rd, e;
        cycle(0, 0, 4'h0, a, 32'h0, rd);
        e = exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : 32'h0;
        chk(rd == e, "R8", "read data", rd, e);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic [AW-1:0] pool [8];
        void'($urandom(32'h5eed_0042));
        repeat (4) @(negedge clk);
        chk(dram_ras_n && dram_we_n && dram_cas_n == 4'hF && !cpu_ack, "R1", "reset pins",
            {dram_ras_n, dram_we_n, dram_cas_n, cpu_ack}, 7'b1111110);
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        chk(dram_ras_n && dram_cas_n == 4'hF && !cpu_ack, "R1", "after reset pins",
            {dram_ras_n, dram_cas_n, cpu_ack}, 6'b111110);
        // R1 / R2: default geometry, and the init burst finishes first.
        cycle(1, 0, 4'h0, '0, 32'h0, rd);
        chk(rd[7:0] == 8'hCC, "R1", "default geometry", rd[7:0], 8'hCC);
        chk(ref_cnt == NI, "R2", "init refresh count", ref_cnt, NI);
        // R10 clamping, both directions.
        set_geom(8'hF3);
        set_geom(8'h00);
        // R7: swapped organisations of equal capacity, edge addresses.
        set_geom(8'hA9);
        mem_write(24'h7FFFF, 4'hF, 32'hDEAD_BEEF);
        mem_write(24'h00000, 4'hF, 32'h0123_4567);
        mem_write(24'h001FF, 4'h5, 32'hAABB_CCDD);
        mem_read(24'h7FFFF); mem_read(24'h00000); mem_read(24'h001FF);
        set_geom(8'h9A);
        mem_write(24'h7FFFF, 4'hF, 32'h5555_AAAA);
        mem_write(24'h003FF, 4'h8, 32'h1100_0000);
        mem_read(24'h7FFFF); mem_read(24'h003FF);
        // R4: idle window sees regular refreshes.
        begin
            int c0;
            c0 = ref_cnt;
            repeat (1000) @(negedge clk);
            chk(ref_cnt - c0 >= 4 && ref_cnt - c0 <= 6, "R4", "idle refresh count",
                ref_cnt - c0, 5);
        end
        // Random traffic; back-to-back cycles keep refresh competing (R5).
        for (int ep = 0; ep < 6; ep++) begin
            int cw, rw, cap;
            cw = 8 + int'($urandom % 5); rw = 8 + int'($urandom % 5);
            set_geom({4'(rw), 4'(cw)});
            cap = 1 << (cw + rw);
            for (int k = 0; k < 8; k++) pool[k] = AW'($urandom % cap);
            pool[0] = AW'(cap - 1);
            for (int n = 0; n < 60; n++) begin
                logic [AW-1:0] a;
                a = pool[$urandom % 8];
                if ($urandom % 2) mem_write(a, 4'($urandom % 15 + 1), $urandom);
                else              mem_read(a);
            end
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule